// File: doc/BRIEF.md
# Filtered Edge-Triggered Event Capture

This block stamps external events with the value of a free-running counter that it receives from outside. One of two raw event inputs is picked: a device pin or the output of an analog comparator. Each raw input crosses into the system clock domain through its own synchroniser. The picked level then goes either straight to an edge detector or through a four-sample glitch filter. When an edge of the chosen polarity arrives, the counter value is copied into a capture register and a capture flag is raised. The flag drives an interrupt request through an enable. The flag is cleared by a software clear strobe or by an interrupt acknowledge.

A capture-block input shuts off capturing while the surrounding timer uses the capture register as its period limit. The filter and edge logic run on the undivided system clock. The counter may advance at a slower, prescaled rate without affecting them.

Top module: `evtcap_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cap_val` is zero and `cap_flag` is low.
- R2: With the filter off, a level change presented on the selected raw input before clock edge 1 updates `cap_val` and `cap_flag` on edge 3. The stored stamp is the `cnt_val` present at edge 3.
- R3: With `filt_en` = 1, the same update happens exactly four edges later, on edge 7.
- R4: With the filter on, a pulse that lasts fewer than four system clocks on the selected input causes no capture. A pulse of four clocks causes one.
- R5: With `edge_rise` = 1, only 0-to-1 transitions capture. With `edge_rise` = 0, only 1-to-0 transitions capture. The opposite direction leaves `cap_val` and `cap_flag` unchanged.
- R6: With `src_sel` = 0 the pin is used, and with `src_sel` = 1 the comparator is used. Changes on the input that is not selected have no effect.
- R7: Changing `src_sel` while the two inputs sit at different levels produces an edge. That edge captures if its direction matches `edge_rise`, and the update occurs on the first clock edge after the change (filter off).
- R8: While `cap_block` = 1, no capture occurs. Releasing it while the selected level is steady causes no capture.
- R9: A new capture overwrites `cap_val` even when `cap_flag` is already set, and `cap_flag` stays set.
- R10: `cap_flag` stays set until a clock edge with `flag_clr` = 1 or `irq_ack` = 1 clears it. If a capture occurs on the same edge, the capture wins and the flag stays set.
- R11: `irq` is high exactly when `cap_flag` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Raw event input from the pin (asynchronous) |
| cmp_in | input | 1 | Raw event input from the comparator (asynchronous) |
| src_sel | input | 1 | Event source: 0 pin, 1 comparator |
| filt_en | input | 1 | Enable the four-sample glitch filter |
| edge_rise | input | 1 | Capture polarity: 1 rising, 0 falling |
| cap_block | input | 1 | Suppress captures (capture register used as period limit) |
| irq_en | input | 1 | Interrupt enable |
| cnt_val | input | CNT_W | Counter value to be stamped |
| flag_clr | input | 1 | Software clear of the capture flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the capture flag |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit stamp, two synchroniser stages and a filter depth of four. It then measures the exact edge on which the flag rises for both filter settings, expecting 3 and 7 edges. The counter is stepped every cycle, so each stamp also confirms that latency. The default depth of four places the reject/accept boundary between 3-clock and 4-clock pulses, and the bench drives pulses on both sides of it. Source switching, blocking, overwrite and the collision of a clear with a capture are each driven directly.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;
  typedef enum logic {SRC_PIN = 1'b0, SRC_CMP = 1'b1} evt_src_e;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/evtcap_sync.sv
module evtcap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/evtcap_filter.sv
module evtcap_filter #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned HW = DEPTH - 1;

  logic [HW-1:0] hist;
  logic [DEPTH-1:0] window;
  logic all_hi, all_lo;

  assign window = {hist, d};
  assign all_hi = &window;
  assign all_lo = ~|window;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      q    <= 1'b0;
    end else begin
      hist <= window[HW-1:0];
      if (all_hi)      q <= 1'b1;
      else if (all_lo) q <= 1'b0;
    end
  end
endmodule

// File: rtl/evtcap_latch.sv
module evtcap_latch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level,
  input  logic             edge_rise,
  input  logic             cap_block,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             flag_clr,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag
);
  logic prev_q;
  logic hit;

  assign hit = (level != prev_q) && (level == edge_rise) && !cap_block;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      cap_val  <= '0;
      cap_flag <= 1'b0;
    end else begin
      prev_q <= level;
      if (hit) cap_val <= cnt_val;
      cap_flag <= hit | (cap_flag & ~(flag_clr | irq_ack));
    end
  end
endmodule

// File: rtl/evtcap_unit.sv
module evtcap_unit
  import evtcap_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_DEPTH  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             cmp_in,
  input  logic             src_sel,
  input  logic             filt_en,
  input  logic             edge_rise,
  input  logic             cap_block,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             flag_clr,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             irq
);
  logic [NUM_SRC-1:0] raw_vec;
  logic [NUM_SRC-1:0] syn_vec;
  logic sel_lvl, filt_lvl, det_lvl;

  assign raw_vec[SRC_PIN] = pin_in;
  assign raw_vec[SRC_CMP] = cmp_in;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    evtcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_async(raw_vec[i]), .q(syn_vec[i])
    );
  end

  assign sel_lvl = (evt_src_e'(src_sel) == SRC_CMP) ? syn_vec[SRC_CMP] : syn_vec[SRC_PIN];

  evtcap_filter #(.DEPTH(FILT_DEPTH)) u_filt (
    .clk(clk), .rst(rst), .d(sel_lvl), .q(filt_lvl)
  );

  assign det_lvl = filt_en ? filt_lvl : sel_lvl;

  evtcap_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst(rst), .level(det_lvl), .edge_rise(edge_rise),
    .cap_block(cap_block), .cnt_val(cnt_val), .flag_clr(flag_clr),
    .irq_ack(irq_ack), .cap_val(cap_val), .cap_flag(cap_flag)
  );

  assign irq = cap_flag & irq_en;
endmodule

// File: rtl/evtcap_checker.sv
module evtcap_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_block,
  input logic [CNT_W-1:0] cnt_val,
  input logic             flag_clr,
  input logic             irq_ack,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_flag
);
  AST_STAMP_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_flag) |-> cap_val == $past(cnt_val)); // R2
  AST_NEW_STAMP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_val) |-> cap_flag); // R9
  AST_BLOCK_HOLDS_VAL: assert property (@(posedge clk) disable iff (rst)
    cap_block |=> $stable(cap_val)); // R8
  AST_BLOCK_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cap_block && !cap_flag) |=> !cap_flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cap_flag && !flag_clr && !irq_ack) |=> cap_flag); // R10
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (cap_block && (flag_clr || irq_ack)) |=> !cap_flag); // R10
endmodule

bind evtcap_unit evtcap_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_evtcap_unit.sv
module tb_evtcap_unit;
  localparam int W = 16;

  logic clk = 0, rst = 1;
  logic pin_in = 0, cmp_in = 0, src_sel = 0, filt_en = 0, edge_rise = 1;
  logic cap_block = 0, irq_en = 0, flag_clr = 0, irq_ack = 0;
  logic [W-1:0] cnt_val = '0;
  logic [W-1:0] cap_val;
  logic cap_flag, irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evtcap_unit dut (.*);

  // [7]src [6]filt [5]rise [4]pre_pin [3]pre_cmp [2]new_pin [1]new_cmp [0]expect
  localparam logic [7:0] VEC [8] = '{
    8'b0_0_1_00_10_1,  // R5 R2 pin rising
    8'b0_0_1_10_00_0,  // R5 falling ignored
    8'b0_0_0_10_00_1,  // R5 falling edge
    8'b1_0_1_00_01_1,  // R6 comparator rising
    8'b1_0_1_00_10_0,  // R6 pin ignored
    8'b0_1_1_00_10_1,  // R3 filtered rising
    8'b1_1_0_01_00_1,  // R3 filtered comparator falling
    8'b0_1_0_11_01_1   // R3 filtered pin falling
  };

  task automatic tick();
    @(negedge clk);
    cnt_val = cnt_val + 1'b1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle_clear();
    repeat (12) tick();
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  task automatic wait_flag(input int maxw, output int k);
    k = 0;
    for (int i = 1; i <= maxw; i++) begin
      tick();
      if (cap_flag) begin k = i; break; end
    end
  endtask

  initial begin
    int k;
    logic [W-1:0] base, held;
    repeat (3) tick();
    chk(cap_val == 0, "R1 reset cap_val", cap_val, 0);
    chk(cap_flag == 0, "R1 reset flag", cap_flag, 0);
    rst = 0; tick();
    chk(cap_val == 0 && cap_flag == 0, "R1 after release", cap_flag, 0);

    for (int v = 0; v < 8; v++) begin
      int lat;
      src_sel = VEC[v][7]; filt_en = VEC[v][6]; edge_rise = VEC[v][5];
      pin_in = VEC[v][4]; cmp_in = VEC[v][3];
      settle_clear();
      held = cap_val; base = cnt_val;
      pin_in = VEC[v][2]; cmp_in = VEC[v][1];
      lat = filt_en ? 7 : 3;
      wait_flag(10, k);
      if (VEC[v][0]) begin
        chk(k == lat, "R2/R3 latency", k, lat);
        chk(cap_val == W'(base + lat - 1), "R2 stamp", cap_val, base + lat - 1);
      end else begin
        chk(k == 0, "R5/R6 no capture flag", k, 0);
        chk(cap_val == held, "R5/R6 cap_val kept", cap_val, held);
      end
    end

    // R4 filter pulse width boundary
    src_sel = 0; filt_en = 1; edge_rise = 1; pin_in = 0; cmp_in = 0;
    settle_clear();
    pin_in = 1; repeat (3) tick(); pin_in = 0;
    wait_flag(12, k);
    chk(k == 0, "R4 3-clock pulse rejected", k, 0);
    settle_clear();
    pin_in = 1; repeat (4) tick(); pin_in = 0;
    wait_flag(12, k);
    chk(k != 0, "R4 4-clock pulse accepted", k, 1);

    // R7 source switch edge
    filt_en = 0; src_sel = 1; pin_in = 1; cmp_in = 0;
    settle_clear();
    base = cnt_val; src_sel = 0;
    wait_flag(5, k);
    chk(k == 1, "R7 switch capture latency", k, 1);
    chk(cap_val == base, "R7 switch stamp", cap_val, base);

    // R8 blocking
    pin_in = 0; cap_block = 1;
    settle_clear();
    held = cap_val; pin_in = 1;
    wait_flag(8, k);
    chk(k == 0 && cap_val == held, "R8 blocked no capture", k, 0);
    cap_block = 0;
    wait_flag(6, k);
    chk(k == 0 && cap_val == held, "R8 release no capture", k, 0);

    // R9 overwrite while flag set
    pin_in = 0; settle_clear();
    pin_in = 1; wait_flag(5, k);
    held = cap_val;
    pin_in = 0; repeat (5) tick();
    base = cnt_val; pin_in = 1; repeat (3) tick();
    chk(cap_val == W'(base + 2) && cap_val != held, "R9 overwrite stamp", cap_val, base + 2);
    chk(cap_flag == 1, "R9 flag still set", cap_flag, 1);

    // R10 clear collides with capture
    pin_in = 0; settle_clear();
    pin_in = 1; tick(); tick();
    flag_clr = 1; tick(); flag_clr = 0;
    chk(cap_flag == 1, "R10 capture beats clear", cap_flag, 1);

    // R11 irq gating and R10 ack clear
    irq_en = 1; #1;
    chk(irq == 1, "R11 irq with enable", irq, 1);
    irq_en = 0; #1;
    chk(irq == 0, "R11 irq masked", irq, 0);
    irq_en = 1;
    irq_ack = 1; tick(); irq_ack = 0;
    chk(cap_flag == 0 && irq == 0, "R10 ack clears flag", cap_flag, 0);
    pin_in = 0; repeat (5) tick();
    pin_in = 1; wait_flag(5, k);
    chk(cap_flag == 1, "R10 flag set again", cap_flag, 1);
    flag_clr = 1; tick(); flag_clr = 0;
    chk(cap_flag == 0, "R10 flag_clr clears", cap_flag, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule